// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load-Use Detector

This block sits beside the register-read step of a five-stage in-order pipeline. It takes the two source register numbers of the instruction being decoded, together with the values the register file returned for them. For each of the three younger-to-older downstream stages (execute, memory, writeback) it also takes the destination register number, a write-enable, the result value, and, for the execute stage, a flag marking a load. It returns two operand values that already reflect every in-flight result, so the decoded instruction never reads a stale register.

When a load in the execute stage targets a register that the decoding instruction reads, the loaded word does not exist yet. The block then raises a stall request. After one stalled cycle the load has moved into the memory stage, and its data is bypassed from there. The block never writes the register file; that stays with writeback. Register zero always reads as its register-file value and never causes a stall.

The block is purely combinational. Both operands and the stall request follow the inputs within the same cycle.

Top module: `opfwd_unit`

## Requirements
- R1: When no qualifying stage destination equals a source number, that operand equals its register-file read value.
- R2: A stage whose write-enable is high and whose destination equals a source number supplies its result value for that operand. For the execute stage this also requires the load flag to be low.
- R3: When several qualifying stages match the same source, the execute stage wins over memory, and memory wins over writeback.
- R4: A source number of 0 always passes its register-file value through and never contributes to the stall request.
- R5: A stage with write-enable low never supplies an operand, even when its destination matches.
- R6: The stall output is 1 exactly when the execute stage has write-enable high, load flag high, a nonzero destination, and that destination equals either source number.
- R7: A load in the execute stage is never a bypass source. A matching operand then takes the next qualifying stage (memory, then writeback, then the register file).
- R8: The two operands are resolved independently under the same rules. A match on one source never changes the other operand.
- R9: All outputs are combinational and reflect the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | REG_W | Register number of first source |
| src_a_rf | input | DATA_W | Register-file value for first source |
| src_b_idx | input | REG_W | Register number of second source |
| src_b_rf | input | DATA_W | Register-file value for second source |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | REG_W | Execute-stage destination register |
| ex_val | input | DATA_W | Execute-stage result |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_W | Memory-stage destination register |
| mem_val | input | DATA_W | Memory-stage result (load data for loads) |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | REG_W | Writeback-stage destination register |
| wb_val | input | DATA_W | Writeback-stage result |
| opnd_a | output | DATA_W | Resolved first operand |
| opnd_b | output | DATA_W | Resolved second operand |
| stall_req | output | 1 | Load-use stall request |

## Verification
Every result of this block is due in the cycle its inputs are applied, with zero register stages between input and output. The bench therefore drives each stimulus on a falling clock edge and samples both operands and the stall request one nanosecond later, inside the same cycle. It sweeps register numbers 0 to 3 over both sources and all three destinations, together with every write-enable and load-flag combination. Each applied vector has fresh data values, so a stale or wrongly routed value cannot match by chance.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    // stage slots, youngest first; the order is the bypass priority
    localparam int STG_EX   = 0;
    localparam int STG_MEM  = 1;
    localparam int STG_WB   = 2;
    localparam int NUM_STG  = 3;

    typedef enum logic [1:0] {
        PICK_RF  = 2'd0,
        PICK_EX  = 2'd1,
        PICK_MEM = 2'd2,
        PICK_WB  = 2'd3
    } pick_e;

    // youngest matching producer wins
    function automatic pick_e choose_src(input logic [NUM_STG-1:0] hit);
        if (hit[STG_EX])       return PICK_EX;
        else if (hit[STG_MEM]) return PICK_MEM;
        else if (hit[STG_WB])  return PICK_WB;
        else                   return PICK_RF;
    endfunction

endpackage

// File: rtl/opfwd_match.sv
module opfwd_match
    import opfwd_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic [REG_W-1:0]              src_idx,
    input  logic [NUM_STG-1:0]            st_ok,
    input  logic [NUM_STG-1:0][REG_W-1:0] st_dst,
    output logic [NUM_STG-1:0]            hit
);
    logic src_live;
    assign src_live = (src_idx != '0);

    for (genvar s = 0; s < NUM_STG; s++) begin : g_cmp
        assign hit[s] = src_live && st_ok[s] && (st_dst[s] == src_idx);
    end
endmodule

// File: rtl/opfwd_select.sv
module opfwd_select
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_STG-1:0]               hit,
    input  logic [DATA_W-1:0]                rf_val,
    input  logic [NUM_STG-1:0][DATA_W-1:0]   st_val,
    output logic [DATA_W-1:0]                opnd
);
    pick_e sel;

    always_comb begin
        sel = choose_src(hit);
        unique case (sel)
            PICK_EX:  opnd = st_val[STG_EX];
            PICK_MEM: opnd = st_val[STG_MEM];
            PICK_WB:  opnd = st_val[STG_WB];
            default:  opnd = rf_val;
        endcase
    end

    always_comb begin
        // R1: nothing matched, the register file value goes through
        if (hit == '0)
            a_r1_rf_pass: assert (opnd == rf_val) else $error("a_r1_rf_pass");
        // R3: execute-stage hit takes precedence
        if (hit[STG_EX])
            a_r3_ex_first: assert (opnd == st_val[STG_EX]) else $error("a_r3_ex_first");
    end
endmodule

// File: rtl/opfwd_hazard.sv
module opfwd_hazard #(
    parameter int REG_W = 4
) (
    input  logic [REG_W-1:0] src_a_idx,
    input  logic [REG_W-1:0] src_b_idx,
    input  logic             ex_wen,
    input  logic             ex_load,
    input  logic [REG_W-1:0] ex_dst,
    output logic             stall_req
);
    logic load_pending;
    logic dep_a, dep_b;

    assign load_pending = ex_wen && ex_load && (ex_dst != '0);
    assign dep_a        = (src_a_idx == ex_dst);
    assign dep_b        = (src_b_idx == ex_dst);
    assign stall_req    = load_pending && (dep_a || dep_b);

    always_comb begin
        // R6: a stall always traces back to a live load in execute
        if (stall_req)
            a_r6_stall_cause: assert (ex_load && ex_wen) else $error("a_r6_stall_cause");
    end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 4
) (
    input  logic [REG_W-1:0]  src_a_idx,
    input  logic [DATA_W-1:0] src_a_rf,
    input  logic [REG_W-1:0]  src_b_idx,
    input  logic [DATA_W-1:0] src_b_rf,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [REG_W-1:0]  ex_dst,
    input  logic [DATA_W-1:0] ex_val,
    input  logic              mem_wen,
    input  logic [REG_W-1:0]  mem_dst,
    input  logic [DATA_W-1:0] mem_val,
    input  logic              wb_wen,
    input  logic [REG_W-1:0]  wb_dst,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic              stall_req
);
    localparam int NUM_SRC = 2;

    logic [NUM_STG-1:0]              st_ok;
    logic [NUM_STG-1:0][REG_W-1:0]   st_dst;
    logic [NUM_STG-1:0][DATA_W-1:0]  st_val;
    logic [NUM_SRC-1:0][REG_W-1:0]   src_idx;
    logic [NUM_SRC-1:0][DATA_W-1:0]  src_rf;
    logic [NUM_SRC-1:0][DATA_W-1:0]  src_out;
    logic [NUM_SRC-1:0][NUM_STG-1:0] src_hit;

    // a load in execute has no data yet: it never qualifies as a source
    assign st_ok[STG_EX]   = ex_wen && !ex_load;
    assign st_ok[STG_MEM]  = mem_wen;
    assign st_ok[STG_WB]   = wb_wen;
    assign st_dst[STG_EX]  = ex_dst;
    assign st_dst[STG_MEM] = mem_dst;
    assign st_dst[STG_WB]  = wb_dst;
    assign st_val[STG_EX]  = ex_val;
    assign st_val[STG_MEM] = mem_val;
    assign st_val[STG_WB]  = wb_val;

    assign src_idx[0] = src_a_idx;
    assign src_idx[1] = src_b_idx;
    assign src_rf[0]  = src_a_rf;
    assign src_rf[1]  = src_b_rf;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        opfwd_match #(.REG_W(REG_W)) u_match (
            .src_idx (src_idx[k]),
            .st_ok   (st_ok),
            .st_dst  (st_dst),
            .hit     (src_hit[k])
        );
        opfwd_select #(.DATA_W(DATA_W)) u_sel (
            .hit    (src_hit[k]),
            .rf_val (src_rf[k]),
            .st_val (st_val),
            .opnd   (src_out[k])
        );
    end

    assign opnd_a = src_out[0];
    assign opnd_b = src_out[1];

    opfwd_hazard #(.REG_W(REG_W)) u_haz (
        .src_a_idx (src_a_idx),
        .src_b_idx (src_b_idx),
        .ex_wen    (ex_wen),
        .ex_load   (ex_load),
        .ex_dst    (ex_dst),
        .stall_req (stall_req)
    );

    always_comb begin
        // R4: register zero is neither bypassed nor a stall cause
        if (src_a_idx == '0)
            a_r4_zero_a: assert (opnd_a == src_a_rf) else $error("a_r4_zero_a");
        if (src_b_idx == '0)
            a_r4_zero_b: assert (opnd_b == src_b_rf) else $error("a_r4_zero_b");
        // R7: the value of a load still in execute never reaches an operand
        if (ex_load && ex_wen && (ex_dst == src_a_idx) && (src_a_idx != '0) && (ex_val != mem_val)
            && (ex_val != wb_val) && (ex_val != src_a_rf))
            a_r7_no_ex_load: assert (opnd_a != ex_val) else $error("a_r7_no_ex_load");
    end
endmodule

// File: tb/opfwd_unit_tb.sv
module opfwd_unit_tb;
    localparam int DW = 32;
    localparam int RW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [RW-1:0] sa, sb, exd, memd, wbd;
    logic [DW-1:0] sarf, sbrf, exv, memv, wbv;
    logic exw, exl, memw, wbw;
    logic [DW-1:0] oa, ob;
    logic st;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    opfwd_unit #(.DATA_W(DW), .REG_W(RW)) u_dut (
        .src_a_idx(sa), .src_a_rf(sarf), .src_b_idx(sb), .src_b_rf(sbrf),
        .ex_wen(exw), .ex_load(exl), .ex_dst(exd), .ex_val(exv),
        .mem_wen(memw), .mem_dst(memd), .mem_val(memv),
        .wb_wen(wbw), .wb_dst(wbd), .wb_val(wbv),
        .opnd_a(oa), .opnd_b(ob), .stall_req(st)
    );

    function automatic logic [DW-1:0] model(input logic [RW-1:0] s, input logic [DW-1:0] rf);
        if (s == 0) return rf;
        if (exw && !exl && exd == s) return exv;
        if (memw && memd == s) return memv;
        if (wbw && wbd == s) return wbv;
        return rf;
    endfunction

    function automatic string tag(input logic [RW-1:0] s);
        int n;
        n = int'(exw && !exl && exd == s) + int'(memw && memd == s) + int'(wbw && wbd == s);
        if (s == 0) return "R4";
        if (exw && exl && exd == s) return "R7";
        if (n > 1) return "R3";
        if ((!exw && exd == s) || (!memw && memd == s) || (!wbw && wbd == s)) return "R5";
        if (n == 1) return "R2";
        return "R1";
    endfunction

    task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    initial begin
        #900000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seq = 0;
        logic exp_st;
        // R9, R1: all-zero inputs, outputs in the same cycle
        sa = 0; sb = 0; exd = 0; memd = 0; wbd = 0;
        exw = 0; exl = 0; memw = 0; wbw = 0;
        sarf = 32'hA5A5_0001; sbrf = 32'h5A5A_0002; exv = 1; memv = 2; wbv = 3;
        @(negedge clk); #1;
        chk("R9", oa, 32'hA5A5_0001);
        chk("R9", ob, 32'h5A5A_0002);
        chk("R9", {31'd0, st}, 0);

        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int e = 0; e < 4; e++)
        for (int m = 0; m < 4; m++)
        for (int w = 0; w < 4; w++)
        for (int f = 0; f < 16; f++) begin
            if ((f & 8) != 0 && (f & 1) == 0) continue; // load flag only with write-enable
            @(negedge clk);
            seq++;
            sa = RW'(a); sb = RW'(b); exd = RW'(e); memd = RW'(m); wbd = RW'(w);
            exw = f[0]; memw = f[1]; wbw = f[2]; exl = f[3];
            sarf = 32'h1000_0000 + seq; sbrf = 32'h2000_0000 + seq;
            exv  = 32'h3000_0000 + seq; memv = 32'h4000_0000 + seq;
            wbv  = 32'h5000_0000 + seq;
            #1;
            // R8: each operand checked against its own source only
            chk(tag(sa), oa, model(sa, sarf));
            chk(tag(sb), ob, model(sb, sbrf));
            exp_st = exw && exl && (exd != 0) && (exd == sa || exd == sb);
            chk("R6", {31'd0, st}, {31'd0, exp_st});
        end

        // R7 follow-up: after the stall the load sits in memory and is bypassed
        @(negedge clk);
        sa = 4'd5; sb = 4'd0; exw = 1; exl = 1; exd = 4'd5; memw = 0; wbw = 0;
        #1;
        chk("R6", {31'd0, st}, 1);
        @(negedge clk);
        exw = 0; exl = 0; memw = 1; memd = 4'd5; memv = 32'hDEAD_BEEF;
        #1;
        chk("R7", oa, 32'hDEAD_BEEF);
        chk("R6", {31'd0, st}, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule